// File: doc/BRIEF.md
# Lockable One-Time Configuration Bit Store

This block keeps a small array of configuration bits. Each bit exists twice: once as a volatile shadow latch and once as a permanent one-time cell that can only be blown from 0 to 1. An upstream serial front end decodes byte commands and hands this block one command per cycle. A command carries an operation and a 6-bit bit address. It can write one shadow latch, program one permanent cell, request a precharge, or clear all shadow latches (remote reset).

A run-time source input picks what the configuration outputs show. When it is high, the outputs show the shadow latches, so a setting can be tried and then changed. When it is low, the outputs show the permanent cells. Address 0 is the lock bit. Once its permanent cell is blown, the outputs always show the permanent cells. From then on only precharge and remote-reset commands are accepted. A count of the set bits in the active source serves as a supply-current indicator.

Top module: `otp_cfg_store`

## Requirements
- R1: Reset is synchronous and active high. It clears every shadow latch, the address error flag and the precharge pulse. The permanent cells keep their values, and all permanent cells start at 0.
- R2: A shadow-write command (op 0) to an implemented address, while unlocked, loads `cmd_val` into that shadow latch. The change shows on the outputs after the same clock edge.
- R3: A program command (op 1) to an implemented address, while unlocked, sets that permanent cell to 1. A permanent cell never returns to 0, including through reset.
- R4: While unlocked, `src_shadow`=1 drives `cfg_bits` from the shadow latches and `src_shadow`=0 drives it from the permanent cells.
- R5: When permanent bit 0 (the lock) is 1, `cfg_bits` equals the permanent cells whatever the value of `src_shadow`.
- R6: While locked, shadow-write and program commands change nothing.
- R7: A remote-reset command (op 3) clears all shadow latches and leaves the permanent cells as they are. It is accepted both locked and unlocked.
- R8: A precharge command (op 2) makes `prech_active` high in the cycle after its edge, both locked and unlocked. While unlocked with `src_shadow`=1, `prech_active` is held high continuously.
- R9: A shadow-write or program command to an address at or above NUM_BITS (8) changes no bit and sets `addr_err`. `addr_err` stays set until reset.
- R10: `set_count` equals the number of ones in `cfg_bits`.
- R11: The fields are decoded from `cfg_bits` as follows: `cfg_lock` is bit 0, `cfg_fast_clk` is bit 1, `cfg_osc_rc` is bit 2, and `cfg_app_mode` is bits 4:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 shadow write, 1 program, 2 precharge, 3 remote reset |
| cmd_addr | input | 6 | Configuration bit address |
| cmd_val | input | 1 | Value for a shadow write |
| src_shadow | input | 1 | 1 selects shadow latches as source (unless locked) |
| cfg_bits | output | 8 | Active configuration bits |
| cfg_lock | output | 1 | Lock / test-disable field |
| cfg_fast_clk | output | 1 | Measurement frequency range field |
| cfg_osc_rc | output | 1 | Oscillator type field |
| cfg_app_mode | output | 2 | Application mode field |
| set_count | output | 4 | Number of set bits in the active source |
| prech_active | output | 1 | Precharge in progress |
| addr_err | output | 1 | Sticky unimplemented-address flag |

## Verification
Every command takes effect at the rising edge that samples it. The bits, the fields and the count follow from that state through logic alone, so they are due in the next low clock phase. The precharge pulse has one register and shows in that same phase for one cycle only. The source select acts without a register and is seen in the phase it is driven. The bench drives inputs on falling edges and updates a reference model after each rising edge. It compares all outputs at the following falling edge, so each result is checked in the cycle it falls due.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;

    localparam int ADDR_W    = 6;
    localparam int MAX_BITS  = 64;

    localparam int POS_LOCK  = 0;
    localparam int POS_FAST  = 1;
    localparam int POS_OSC   = 2;
    localparam int POS_MODE  = 3;

    typedef enum logic [1:0] {
        OP_SHADOW_WR = 2'd0,
        OP_PROGRAM   = 2'd1,
        OP_PRECHARGE = 2'd2,
        OP_REMOTE_RST= 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic wr_shadow;
        logic wr_perm;
        logic clr_shadow;
        logic prech;
        logic bad_addr;
        logic val;
    } cfg_act_t;

    typedef struct packed {
        logic       lock;
        logic       fast_clk;
        logic       osc_rc;
        logic [1:0] app_mode;
    } cfg_fields_t;

    function automatic logic [6:0] count_ones(input logic [MAX_BITS-1:0] v);
        logic [6:0] n;
        n = '0;
        for (int i = 0; i < MAX_BITS; i++) begin
            n = n + {6'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
    import otp_cfg_pkg::*;
#(
    parameter int NUM_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                cmd_val,
    input  logic                locked,
    output cfg_act_t            act,
    output logic [NUM_BITS-1:0] sel
);

    cfg_op_e op;
    logic    addr_ok;
    logic    is_write;

    assign op       = cfg_op_e'(cmd_op);
    assign addr_ok  = int'(cmd_addr) < NUM_BITS;
    assign is_write = cmd_valid && (op == OP_SHADOW_WR || op == OP_PROGRAM);

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_sel
        assign sel[i] = (int'(cmd_addr) == i);
    end

    always_comb begin
        act            = '0;
        act.val        = cmd_val;
        act.wr_shadow  = is_write && op == OP_SHADOW_WR && addr_ok && !locked;
        act.wr_perm    = is_write && op == OP_PROGRAM   && addr_ok && !locked;
        act.clr_shadow = cmd_valid && op == OP_REMOTE_RST;
        act.prech      = cmd_valid && op == OP_PRECHARGE;
        act.bad_addr   = is_write && !addr_ok;
    end

    p_locked_blocks_writes_r6: assert property (@(posedge clk) disable iff (rst)
        locked |-> !(act.wr_shadow || act.wr_perm));

    p_one_action_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({act.wr_shadow, act.wr_perm, act.clr_shadow, act.prech, act.bad_addr}) <= 1);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_cfg_pkg::*;
#(
    parameter int NUM_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  cfg_act_t            act,
    input  logic [NUM_BITS-1:0] sel,
    output logic [NUM_BITS-1:0] shadow_q,
    output logic [NUM_BITS-1:0] perm_q
);

    logic [NUM_BITS-1:0] shadow_d;
    logic [NUM_BITS-1:0] perm_d;
    logic [NUM_BITS-1:0] perm_r = '0;

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        assign shadow_d[i] = act.clr_shadow             ? 1'b0    :
                             (act.wr_shadow && sel[i])  ? act.val :
                                                          shadow_q[i];
        assign perm_d[i]   = perm_r[i] | (act.wr_perm && sel[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            perm_r <= perm_d;
        end
    end

    assign perm_q = perm_r;

    p_perm_never_falls_r3: assert property (@(posedge clk)
        1'b1 |=> ((perm_r & $past(perm_r)) == $past(perm_r)));

    p_rreset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        act.clr_shadow |=> (shadow_q == '0));

    p_locked_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (perm_r[POS_LOCK] && !act.clr_shadow) |=> $stable(shadow_q));

endmodule

// File: rtl/otp_src_select.sv
module otp_src_select
    import otp_cfg_pkg::*;
#(
    parameter int NUM_BITS = 8,
    parameter int CNT_W    = $clog2(NUM_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_shadow,
    input  logic [NUM_BITS-1:0] shadow_q,
    input  logic [NUM_BITS-1:0] perm_q,
    output logic [NUM_BITS-1:0] active,
    output cfg_fields_t         fields,
    output logic [CNT_W-1:0]    count
);

    logic                use_shadow;
    logic [MAX_BITS-1:0] wide;
    logic [6:0]          ones;

    assign use_shadow = src_shadow && !perm_q[POS_LOCK];
    assign active     = use_shadow ? shadow_q : perm_q;
    assign wide       = MAX_BITS'(active);
    assign ones       = count_ones(wide);
    assign count      = CNT_W'(ones);

    always_comb begin
        fields          = '0;
        fields.lock     = active[POS_LOCK];
        fields.fast_clk = active[POS_FAST];
        fields.osc_rc   = active[POS_OSC];
        fields.app_mode = active[POS_MODE+1:POS_MODE];
    end

    p_locked_uses_perm_r5: assert property (@(posedge clk) disable iff (rst)
        perm_q[POS_LOCK] |-> (active == perm_q));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= NUM_BITS);

endmodule

// File: rtl/otp_cfg_store.sv
module otp_cfg_store
    import otp_cfg_pkg::*;
#(
    parameter int NUM_BITS = 8,
    parameter int CNT_W    = $clog2(NUM_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [5:0]          cmd_addr,
    input  logic                cmd_val,
    input  logic                src_shadow,
    output logic [NUM_BITS-1:0] cfg_bits,
    output logic                cfg_lock,
    output logic                cfg_fast_clk,
    output logic                cfg_osc_rc,
    output logic [1:0]          cfg_app_mode,
    output logic [CNT_W-1:0]    set_count,
    output logic                prech_active,
    output logic                addr_err
);

    cfg_act_t            act;
    cfg_fields_t         fields;
    logic [NUM_BITS-1:0] sel;
    logic [NUM_BITS-1:0] shadow_q;
    logic [NUM_BITS-1:0] perm_q;
    logic                prech_q;
    logic                err_q;

    otp_cmd_decode #(.NUM_BITS(NUM_BITS)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_val  (cmd_val),
        .locked   (perm_q[POS_LOCK]),
        .act      (act),
        .sel      (sel)
    );

    otp_cell_array #(.NUM_BITS(NUM_BITS)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .sel     (sel),
        .shadow_q(shadow_q),
        .perm_q  (perm_q)
    );

    otp_src_select #(.NUM_BITS(NUM_BITS), .CNT_W(CNT_W)) u_select (
        .clk       (clk),
        .rst       (rst),
        .src_shadow(src_shadow),
        .shadow_q  (shadow_q),
        .perm_q    (perm_q),
        .active    (cfg_bits),
        .fields    (fields),
        .count     (set_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prech_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            prech_q <= act.prech;
            err_q   <= err_q | act.bad_addr;
        end
    end

    assign cfg_lock     = fields.lock;
    assign cfg_fast_clk = fields.fast_clk;
    assign cfg_osc_rc   = fields.osc_rc;
    assign cfg_app_mode = fields.app_mode;
    assign prech_active = (src_shadow && !perm_q[POS_LOCK]) || prech_q;
    assign addr_err     = err_q;

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> addr_err);

    p_prech_cont_r8: assert property (@(posedge clk) disable iff (rst)
        (src_shadow && !cfg_lock && !perm_q[POS_LOCK]) |-> prech_active);

    p_prech_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |=> prech_active);

endmodule

// File: tb/otp_cfg_store_tb.sv
module otp_cfg_store_tb;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [5:0] cmd_addr = 6'd0;
    logic       cmd_val = 1'b0;
    logic       src_shadow = 1'b0;
    logic [N-1:0] cfg_bits;
    logic       cfg_lock, cfg_fast_clk, cfg_osc_rc, prech_active, addr_err;
    logic [1:0] cfg_app_mode;
    logic [3:0] set_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_sh = '0;
    logic [N-1:0] m_pm = '0;
    logic         m_err = 0;
    logic         m_pulse = 0;

    always #5 clk = ~clk;

    otp_cfg_store u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_val(cmd_val), .src_shadow(src_shadow),
        .cfg_bits(cfg_bits), .cfg_lock(cfg_lock), .cfg_fast_clk(cfg_fast_clk),
        .cfg_osc_rc(cfg_osc_rc), .cfg_app_mode(cfg_app_mode),
        .set_count(set_count), .prech_active(prech_active), .addr_err(addr_err)
    );

    function automatic logic [N-1:0] exp_bits();
        return (src_shadow && !m_pm[0]) ? m_sh : m_pm;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] e;
        e = exp_bits();
        chk({tag, " R4/R5 cfg_bits"}, 32'(cfg_bits), 32'(e));
        chk({tag, " R10 set_count"}, 32'(set_count), 32'($countones(e)));
        chk({tag, " R11 fields"},
            32'({cfg_lock, cfg_fast_clk, cfg_osc_rc, cfg_app_mode}),
            32'({e[0], e[1], e[2], e[4:3]}));
        chk({tag, " R8 prech_active"}, 32'(prech_active),
            32'((src_shadow && !m_pm[0]) || m_pulse));
        chk({tag, " R9 addr_err"}, 32'(addr_err), 32'(m_err));
    endtask

    task automatic cyc(input logic r, input logic v, input logic [1:0] op,
                       input logic [5:0] a, input logic d, input logic s, input string tag);
        rst = r; cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_val = d; src_shadow = s;
        @(posedge clk);
        #1;
        if (r) begin
            m_sh = '0; m_err = 0; m_pulse = 0;
        end else begin
            m_pulse = v && op == 2'd2;
            if (v && (op == 2'd0 || op == 2'd1) && a >= N) m_err = 1;
            if (v && op == 2'd3) m_sh = '0;
            if (v && !m_pm[0] && a < N) begin
                if (op == 2'd0) m_sh[a] = d;
                if (op == 2'd1) m_pm[a] = 1'b1;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, 0, "R1 reset");
        cyc(1, 0, 0, 0, 0, 1, "R1 reset shadow view");
        // R2: shadow writes seen with shadow source
        cyc(0, 1, 0, 6'd1, 1, 1, "R2 write fast");
        cyc(0, 1, 0, 6'd4, 1, 1, "R2 write mode msb");
        cyc(0, 1, 0, 6'd7, 1, 1, "R2 write spare");
        cyc(0, 1, 0, 6'd7, 0, 1, "R2 clear spare");
        // R4: permanent view still empty
        cyc(0, 0, 0, 0, 0, 0, "R4 perm view");
        // R3: program cells
        cyc(0, 1, 1, 6'd2, 0, 0, "R3 program osc");
        cyc(0, 1, 1, 6'd2, 0, 0, "R3 program again");
        cyc(0, 1, 1, 6'd3, 0, 0, "R3 program mode lsb");
        // R9: bad addresses
        cyc(0, 1, 0, 6'd8, 1, 1, "R9 bad shadow");
        cyc(0, 1, 1, 6'd63, 0, 0, "R9 bad program");
        cyc(0, 0, 0, 0, 0, 0, "R9 sticky");
        // R8: precharge pulse
        cyc(0, 1, 2, 0, 0, 0, "R8 precharge");
        cyc(0, 0, 0, 0, 0, 0, "R8 pulse ends");
        // R7: remote reset
        cyc(0, 1, 3, 0, 0, 1, "R7 remote reset");
        // R1: reset keeps perm, clears err
        cyc(0, 1, 0, 6'd5, 1, 1, "R1 pre");
        cyc(1, 0, 0, 0, 0, 1, "R1 reset again");
        cyc(0, 0, 0, 0, 0, 0, "R1 perm kept");
        // random phase while unlocked (never program address 0)
        for (int i = 0; i < 300; i++) begin
            logic [1:0] op;
            logic [5:0] a;
            op = 2'($urandom_range(3));
            a  = 6'($urandom_range(10));
            if (op == 2'd1 && a == 0) a = 6'd5;
            cyc(($urandom_range(40) == 0), 1'($urandom_range(1)), op, a,
                1'($urandom_range(1)), 1'($urandom_range(1)), "rand unlocked");
        end
        // R5: lock
        cyc(0, 1, 0, 6'd6, 1, 1, "R5 shadow pre-lock");
        cyc(0, 1, 1, 6'd0, 0, 1, "R5 lock programmed");
        cyc(0, 0, 0, 0, 0, 1, "R5 shadow src ignored");
        // R6: writes ignored while locked
        cyc(0, 1, 1, 6'd7, 0, 0, "R6 program ignored");
        cyc(0, 1, 0, 6'd1, 1, 0, "R6 shadow ignored");
        cyc(0, 1, 2, 0, 0, 1, "R8 locked precharge");
        cyc(0, 1, 3, 0, 0, 0, "R7 locked remote reset");
        for (int i = 0; i < 200; i++) begin
            cyc(($urandom_range(40) == 0), 1'($urandom_range(1)),
                2'($urandom_range(3)), 6'($urandom_range(10)),
                1'($urandom_range(1)), 1'($urandom_range(1)), "rand locked");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule